// File: doc/BRIEF.md
# Pointer-Addressed Configuration Register Bank

This block is the register file of a transmitter controller. It sits behind a byte-level serial-bus target: a front end outside this block detects start conditions and delivers whole received bytes, and it asks for each byte to send back. The first byte after a start carries the 7-bit target address and a direction bit. In a write, the next byte loads an internal 8-bit pointer and every byte after that is stored at the pointer, which then advances. A read returns the byte at the pointer, and the pointer advances after each byte delivered, so a host sets the pointer with a short write and then streams consecutive registers.

The writable registers hold operating mode, amplifier enable, encoder rate, modulation variant, pulse-filter enable, amplifier power step and synthesizer channel offset. These registers drive the outputs to the datapath. Writing zero to the control register also raises a one-cycle clear request for the transmit buffer and its counters. A reset register restores every command register to zero. Read-only locations present a BCD firmware version, lock and power-good flags, the transmit-ready flag and three 16-bit telemetry values split into upper and lower bytes.

Top module: `i2c_regbank`

## Requirements
- R1: The block responds only when the address byte after a start has bits 7:1 equal to 0x26. Bit 0 = 1 selects a read and bit 0 = 0 selects a write. For any other address, `sel` stays low and the bytes that follow change no register.
- R2: In a write, the byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then advances by one.
- R3: In a read, `rd_data` shows the register at the pointer. Each `rd_req` pulse advances the pointer by one, starting from the value a preceding write left.
- R4: After `rst_n` is released, all command registers read 0x00. `mode`, `pa_on`, `rate`, `oqpsk`, `pwr_level`, `synth_off` and `buf_clear` are 0, `filter_en` is 1 and `sel` is 0.
- R5: The control register at 0x00 uses bit 7 for amplifier enable and bits 1:0 for mode (00 configuration, 01 sync, 10 data, 11 test). `pa_on` is 1 only when bit 7 is set and the mode is not 00. Bits 6:2 read back as 0.
- R6: The encoder register at 0x01 uses bits 1:0 for rate (0 full, 1 half, 2 quarter, 3 eighth), bit 2 for modulation (0 QPSK, 1 OQPSK) and bit 3 as an active-low filter enable (`filter_en` = !bit 3). Bits 7:4 read back as 0.
- R7: Register 0x03 keeps bits 1:0 as `pwr_level`. Register 0x04 keeps bits 6:0 as `synth_off`. Their other bits read back as 0.
- R8: Writing a byte with bit 0 = 0 to 0x05 returns registers 0x00 to 0x04 and the pointer to 0. Writing a byte with bit 0 = 1 changes nothing. 0x05 reads back as 0x00.
- R9: Writing 0x00 to the control register sets `buf_clear` for exactly the one cycle after that byte is taken. Writing a nonzero value to it does not set `buf_clear`.
- R10: Read-only map. 0x11 holds {major, minor} BCD (the defaults give 0x17). 0x12 holds {6'b0, power_good, lock}. 0x13 holds {7'b0, ready}. 0x14/0x15, 0x16/0x17 and 0x18/0x19 hold the underrun, overrun and buffer-level values as upper and lower bytes.
- R11: Any address with no register, including 0x02, reads 0x00. A write to such an address, or to a read-only location, has no effect.
- R12: The pointer advances from 0xFF to 0x00, in both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_start | input | 1 | Start or repeated start seen on the bus |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rd_req | input | 1 | Controller has taken `rd_data`; advance pointer |
| rd_data | output | 8 | Register at the current pointer |
| sel | output | 1 | Block is addressed in the current transaction |
| tx_ready | input | 1 | Transmit-ready flag |
| synth_lock | input | 1 | Synthesizer lock flag |
| pa_pwr_good | input | 1 | Amplifier supply good flag |
| underrun_cnt | input | 16 | Underrun count |
| overrun_cnt | input | 16 | Overrun count |
| buf_level | input | LEVEL_W | Buffer occupancy |
| mode | output | 2 | Operating mode |
| pa_on | output | 1 | Gated amplifier enable |
| rate | output | 2 | Encoder rate select |
| oqpsk | output | 1 | Offset modulation select |
| filter_en | output | 1 | Pulse-shaping filter enable |
| pwr_level | output | 2 | Amplifier power step |
| synth_off | output | 7 | Synthesizer channel offset |
| buf_clear | output | 1 | One-cycle buffer/counter clear request |

## Verification
The pointer wrap is the hardest case to reach from the ports. It only shows when a transaction crosses 0xFF. The stimulus sets the pointer to 0xFF and then either sends two data bytes in one write or reads two bytes in a row, so the second byte lands on or comes from the control register at 0x00. A second hard case is the soft reset, which also moves the pointer. It is checked by reading outputs that were nonzero before the reset, both after a write with bit 0 = 1 and after one with bit 0 = 0.

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter logic [6:0] DEV_ADDR = 7'h26,
  parameter int FW_MAJOR = 1,
  parameter int FW_MINOR = 7,
  parameter int LEVEL_W  = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_start,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic               rd_req,
  output logic [7:0]         rd_data,
  output logic               sel,
  input  logic               tx_ready,
  input  logic               synth_lock,
  input  logic               pa_pwr_good,
  input  logic [15:0]        underrun_cnt,
  input  logic [15:0]        overrun_cnt,
  input  logic [LEVEL_W-1:0] buf_level,
  output logic [1:0]         mode,
  output logic               pa_on,
  output logic [1:0]         rate,
  output logic               oqpsk,
  output logic               filter_en,
  output logic [1:0]         pwr_level,
  output logic [6:0]         synth_off,
  output logic               buf_clear
);
  localparam logic [7:0] FW_BCD = 8'((FW_MAJOR % 16) * 16 + (FW_MINOR % 16));
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_PTR = 3'd2, S_WR = 3'd3, S_RD = 3'd4;

  logic [2:0] st;
  logic [7:0] ptr;
  logic       pa_bit;
  logic [1:0] mode_r;
  logic [3:0] enc_r;
  logic [1:0] pwr_r;
  logic [6:0] syn_r;
  logic       clr_r;
  logic [15:0] lvl16;

  wire wr_en    = rx_valid && !bus_start && st == S_WR;
  wire soft_rst = wr_en && ptr == 8'h05 && !rx_data[0];

  assign lvl16 = 16'(buf_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; pa_bit <= 1'b0; mode_r <= '0;
      enc_r <= '0; pwr_r <= '0; syn_r <= '0; clr_r <= 1'b0;
    end else begin
      clr_r <= 1'b0;
      if (bus_start) st <= S_ADDR;
      else if (rx_valid) begin
        case (st)
          S_ADDR: st <= (rx_data[7:1] == DEV_ADDR) ? (rx_data[0] ? S_RD : S_PTR) : S_IDLE;
          S_PTR:  begin ptr <= rx_data; st <= S_WR; end
          S_WR:   ptr <= ptr + 8'd1;
          default: ;
        endcase
      end else if (rd_req && st == S_RD) ptr <= ptr + 8'd1;
      if (wr_en) begin
        case (ptr)
          8'h00: begin pa_bit <= rx_data[7]; mode_r <= rx_data[1:0]; clr_r <= (rx_data == 8'h00); end
          8'h01: enc_r <= rx_data[3:0];
          8'h03: pwr_r <= rx_data[1:0];
          8'h04: syn_r <= rx_data[6:0];
          default: ;
        endcase
      end
      if (soft_rst) begin
        pa_bit <= 1'b0; mode_r <= '0; enc_r <= '0; pwr_r <= '0; syn_r <= '0; ptr <= '0;
      end
    end
  end

  always_comb begin
    case (ptr)
      8'h00: rd_data = {pa_bit, 5'b0, mode_r};
      8'h01: rd_data = {4'b0, enc_r};
      8'h03: rd_data = {6'b0, pwr_r};
      8'h04: rd_data = {1'b0, syn_r};
      8'h11: rd_data = FW_BCD;
      8'h12: rd_data = {6'b0, pa_pwr_good, synth_lock};
      8'h13: rd_data = {7'b0, tx_ready};
      8'h14: rd_data = underrun_cnt[15:8];
      8'h15: rd_data = underrun_cnt[7:0];
      8'h16: rd_data = overrun_cnt[15:8];
      8'h17: rd_data = overrun_cnt[7:0];
      8'h18: rd_data = lvl16[15:8];
      8'h19: rd_data = lvl16[7:0];
      default: rd_data = 8'h00;
    endcase
  end

  assign sel       = (st == S_PTR) || (st == S_WR) || (st == S_RD);
  assign mode      = mode_r;
  assign pa_on     = pa_bit && (mode_r != 2'b00);
  assign rate      = enc_r[1:0];
  assign oqpsk     = enc_r[2];
  assign filter_en = !enc_r[3];
  assign pwr_level = pwr_r;
  assign synth_off = syn_r;
  assign buf_clear = clr_r;

  AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && rx_valid && !bus_start && rx_data[7:1] != DEV_ADDR) |=> !sel); // R1
  AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && rd_req && !rx_valid && !bus_start) |=> ptr == $past(ptr) + 8'd1); // R3
  AST_PA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pa_on) |-> (mode != 2'b00)); // R5
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mode == 2'b00 && rate == 2'b00 && synth_off == 7'd0 && pwr_level == 2'b00)); // R8
  AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == 8'h00 && rx_data == 8'h00) |=> buf_clear); // R9
  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr > 8'h05) |=> ($stable(mode) && $stable(rate) && $stable(synth_off) && $stable(pwr_level))); // R11
endmodule

// File: tb/test_i2c_regbank.sv
module test_i2c_regbank;
  logic clk = 0, rst_n = 0, bus_start = 0, rx_valid = 0, rd_req = 0;
  logic [7:0] rx_data = 0, rd_data;
  logic sel, tx_ready = 0, synth_lock = 0, pa_pwr_good = 0;
  logic [15:0] underrun_cnt = 0, overrun_cnt = 0;
  logic [12:0] buf_level = 0;
  logic [1:0] mode, rate, pwr_level;
  logic pa_on, oqpsk, filter_en, buf_clear;
  logic [6:0] synth_off;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  localparam logic [7:0] WADDR = 8'h4C, RADDR = 8'h4D;
  // {pointer, written byte, expected read-back}
  localparam logic [23:0] VEC [10] = '{
    24'h00_83_83, 24'h00_7F_03, 24'h01_FF_0F, 24'h01_05_05, 24'h03_FE_02,
    24'h04_FF_7F, 24'h02_AA_00, 24'h11_00_17, 24'h05_01_00, 24'h13_FF_00 };

  always #5 clk = ~clk;

  i2c_regbank i_i2c_regbank (.clk, .rst_n, .bus_start, .rx_valid, .rx_data, .rd_req, .rd_data, .sel,
    .tx_ready, .synth_lock, .pa_pwr_good, .underrun_cnt, .overrun_cnt, .buf_level,
    .mode, .pa_on, .rate, .oqpsk, .filter_en, .pwr_level, .synth_off, .buf_clear);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask
  task automatic start(); bus_start = 1; @(negedge clk); bus_start = 0; endtask
  task automatic put(input logic [7:0] b); rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0; endtask
  task automatic wr_reg(input logic [7:0] p, input logic [7:0] d); start(); put(WADDR); put(p); put(d); endtask
  task automatic open_rd(input logic [7:0] p); start(); put(WADDR); put(p); start(); put(RADDR); endtask
  task automatic rd_next(output logic [7:0] b); b = rd_data; rd_req = 1; @(negedge clk); rd_req = 0; endtask

  initial begin
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        bad++; total++; $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad); $finish;
      end
    end
  end

  initial begin
    logic [7:0] b;
    logic [7:0] exp_st [8];
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R4 reset state
    chk({mode, pa_on, rate, oqpsk, pwr_level, synth_off, buf_clear, sel} == 0 && filter_en, "R4",
        {mode, pa_on, rate, oqpsk, pwr_level, synth_off, buf_clear, sel, filter_en}, 1);
    open_rd(8'h00); rd_next(b); chk(b == 8'h00, "R4 ctrl", b, 0);
    open_rd(8'h01); rd_next(b); chk(b == 8'h00, "R4 enc", b, 0);

    // R2/R3/R5/R6/R7/R8/R10/R11 vector walk
    foreach (VEC[i]) begin
      wr_reg(VEC[i][23:16], VEC[i][15:8]);
      open_rd(VEC[i][23:16]); rd_next(b);
      chk(b == VEC[i][7:0], "R2 R3 R5 R6 R7 R10 R11 vector", b, VEC[i][7:0]);
    end
    // R6 R7 outputs after walk (encoder 0x05, power 0x02, offset 0x7F)
    chk(rate == 2'd1 && oqpsk && filter_en, "R6", {rate, oqpsk, filter_en}, 3'b011 << 1 | 1);
    chk(pwr_level == 2'd2 && synth_off == 7'h7F, "R7", {pwr_level, synth_off}, {2'd2, 7'h7F});
    chk(mode == 2'd3 && !pa_on, "R5 bit7 clear", {mode, pa_on}, 6);

    // R5 amplifier gated in configuration mode
    wr_reg(8'h00, 8'h80);
    chk(!buf_clear, "R9 nonzero write", buf_clear, 0);
    chk(!pa_on && mode == 0, "R5 config gate", pa_on, 0);
    wr_reg(8'h00, 8'h82);
    chk(pa_on && mode == 2, "R5 data mode", {mode, pa_on}, 5);

    // R9 clear pulse exactly one cycle
    wr_reg(8'h00, 8'h00);
    chk(buf_clear, "R9 pulse", buf_clear, 1);
    @(negedge clk);
    chk(!buf_clear, "R9 one cycle", buf_clear, 0);

    // R1 foreign address ignored
    start(); put(8'h4E);
    chk(!sel, "R1 sel", sel, 0);
    put(8'h01); put(8'hFF);
    chk(rate == 2'd1 && !sel, "R1 ignored", rate, 1);
    start(); put(WADDR);
    chk(sel, "R1 matched", sel, 1);

    // R8 soft reset
    wr_reg(8'h05, 8'h01);
    chk(rate == 2'd1 && synth_off == 7'h7F, "R8 bit0 one", {rate, synth_off}, {2'd1, 7'h7F});
    wr_reg(8'h00, 8'h81);
    wr_reg(8'h05, 8'hFE);
    chk({mode, pa_on, rate, oqpsk, pwr_level, synth_off} == 0 && filter_en, "R8 reset",
        {mode, pa_on, rate, oqpsk, pwr_level, synth_off}, 0);

    // R10 read-only telemetry with R3 auto-increment
    tx_ready = 1; synth_lock = 1; pa_pwr_good = 0;
    underrun_cnt = 16'hA1B2; overrun_cnt = 16'h0C3D; buf_level = 13'h1234;
    exp_st = '{8'h01, 8'h01, 8'hA1, 8'hB2, 8'h0C, 8'h3D, 8'h12, 8'h34};
    open_rd(8'h12);
    for (int k = 0; k < 8; k++) begin
      rd_next(b); chk(b == exp_st[k], "R10 R3 stream", b, exp_st[k]);
    end

    // R12 wrap on write then on read
    start(); put(WADDR); put(8'hFF); put(8'h55); put(8'h81);
    chk(mode == 2'd1 && pa_on, "R12 write wrap", {mode, pa_on}, 3);
    open_rd(8'hFF); rd_next(b);
    chk(b == 8'h00, "R12 R11 read ff", b, 0);
    rd_next(b);
    chk(b == 8'h81, "R12 read wrap", b, 8'h81);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule